// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between an on-chip host and an asynchronous extended-data-out DRAM of 131,072 sixteen-bit words. A host request carries a 17-bit word address, a write flag, two byte enables and write data. The controller turns each request into a strobe sequence on a multiplexed 9-bit address bus: row on the row strobe, then column on the column strobes. It drives the write-enable and output-enable lines and the enable of the data-bus drivers, and it returns read data with a one-cycle valid pulse.

After a row has been opened, the controller holds it open. Later requests to the same row are served by column-strobe cycles alone, and reads and writes may be mixed within one row period. A request to another row, or a refresh request from the separate refresh generator, first closes the row. A refresh is served as a column-before-row cycle and acknowledged with a pulse. After reset, the controller waits a programmable pause and issues a programmable number of row-only dummy cycles. Only then does it accept host traffic. All DRAM timing limits are parameters counted in controller clocks. The defaults suit a 50 ns part at a 10 ns clock.

Top module: `edo_ctrl`

## Requirements
- R1: After reset, the row strobe, both column strobes, write enable and output enable are high, the bus driver enable is low and `req_ready` is low. `req_ready` stays low for at least PAUSE_CYC clocks, and the row strobe does not fall during the pause.
- R2: After the pause, exactly INIT_CYC row-strobe pulses are issued with both column strobes high before `req_ready` first rises.
- R3: At a row-strobe fall for a host access, the address bus carries address bits 16..8. At each column-strobe fall, bus bits 7..0 carry address bits 7..0.
- R4: Byte enable bit 0 drives the lower strobe, which covers data bits 7..0, and bit 1 drives the upper strobe, which covers bits 15..8. A disabled lane's strobe stays high, that lane reads back as zero, and its memory byte is left unchanged. Byte enable 2'b00 is not allowed.
- R5: For a write, write enable is low, output enable is high and the bus driver is enabled before the column strobe falls. Write data stays stable while the strobe is low.
- R6: For a read, write enable is high and output enable is low. Data is captured when the column strobe has been low for T_CAS clocks. `rd_valid` pulses once, in the cycle after the capture edge. For an open-row read it is seen T_CAS+2 clocks after the accept edge.
- R7: A request to the open row is served with no new row-strobe fall.
- R8: A request to another row raises both strobe groups. The row strobe stays high at least T_RP clocks before it falls again.
- R9: The row strobe stays low at least T_RAS clocks. The column strobes stay low at least T_CAS clocks, stay high at least T_CP clocks between pulses in one row period, and fall no sooner than T_RCD clocks after the row strobe.
- R10: While `ref_req` is high, `req_ready` is low. The controller closes any open row, lowers the column strobes before the row strobe with write enable high and the bus driver off, and pulses `ref_ack` once. Stored data is unchanged.
- R11: Reads and writes may alternate within one row period and each returns or stores correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_addr | input | 17 | Word address: row bits 16..8, column bits 7..0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read data pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh request level from the refresh generator |
| ref_ack | output | 1 | One-cycle pulse when a refresh cycle has been issued |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable of the data-bus drivers |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
A wrong open-row register or hit compare shows at the ports in two ways. A page hit gains an extra row-strobe fall, or a row miss is served as a hit, so the DRAM sees the wrong row and the next read returns the wrong data. A wrong timer load shortens a strobe width or a precharge gap at the very next transition, so the bench's width monitor catches it within one DRAM cycle. A broken byte-lane map or read mask corrupts the first byte read after the faulty write.

// File: rtl/edo_pkg.sv
package edo_pkg;

    localparam int ROW_W  = 9;
    localparam int COL_W  = 8;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int NBYTE  = 2;
    localparam int DATA_W = 8 * NBYTE;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_INIT_ROW,
        ST_IDLE,
        ST_ROW,
        ST_COLSET,
        ST_STROBE,
        ST_OPEN,
        ST_PRECH,
        ST_CBR_SETUP,
        ST_CBR_ROW
    } seq_state_t;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [NBYTE-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } host_op_t;

    typedef struct packed {
        logic              ras_n;
        logic [NBYTE-1:0]  cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [ROW_W-1:0]  addr;
        logic [DATA_W-1:0] dq;
    } dram_pins_t;

    localparam dram_pins_t PINS_QUIET = '{
        ras_n: 1'b1, cas_n: '1, we_n: 1'b1, oe_n: 1'b1,
        dq_oe: 1'b0, addr: '0, dq: '0
    };

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic host_op_t pack_op(input logic [ADDR_W-1:0] a,
                                         input logic wr,
                                         input logic [NBYTE-1:0] be,
                                         input logic [DATA_W-1:0] d);
        host_op_t o;
        o.row   = a[ADDR_W-1:COL_W];
        o.col   = a[COL_W-1:0];
        o.wr    = wr;
        o.be    = be;
        o.wdata = d;
        return o;
    endfunction

endpackage

// File: rtl/edo_pwrup.sv
module edo_pwrup #(
    parameter int PAUSE_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    output logic pause_done
);
    localparam int CW = $clog2(PAUSE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            pause_done <= 1'b0;
        end else if (!pause_done) begin
            if (cnt == CW'(PAUSE_CYC - 1)) begin
                pause_done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/edo_pagetrk.sv
module edo_pagetrk import edo_pkg::*; #(
    parameter int T_RAS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             row_load,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] req_row,
    output logic             hit,
    output logic             ras_ok
);
    localparam int AW = $clog2(T_RAS + 1);

    logic [ROW_W-1:0] open_row;
    logic [AW-1:0]    age;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_row <= '0;
            age      <= '0;
        end else begin
            if (row_load) open_row <= row_in;
            if (ras_n) begin
                age <= '0;
            end else if (age != AW'(T_RAS)) begin
                age <= age + 1'b1;
            end
        end
    end

    assign hit    = (req_row == open_row);
    assign ras_ok = (age >= AW'(T_RAS - 1));
endmodule

// File: rtl/edo_seq.sv
module edo_seq import edo_pkg::*; #(
    parameter int INIT_CYC = 8,
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 1,
    parameter int T_RAS    = 5,
    parameter int T_RP     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pause_done,
    input  logic              hit,
    input  logic              ras_ok,
    input  logic              req_valid,
    input  host_op_t          host_op,
    input  logic              ref_req,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ref_ack,
    output dram_pins_t        pins,
    output logic              row_load
);
    localparam int TMAX = imax(imax(imax(T_RCD, T_CAS), imax(T_CP, T_RAS)), T_RP);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int IW   = $clog2(INIT_CYC + 1);

    seq_state_t        state;
    logic [TW-1:0]     tmr;
    logic [IW-1:0]     init_left;
    host_op_t          cur;
    host_op_t          nxt;
    logic [DATA_W-1:0] rd_masked;
    logic              idle_take;
    logic              open_take;
    logic              open_close;

    // operation fed into the column phase: a fresh host op on a page hit,
    // otherwise the op latched when the row was opened
    assign nxt = (state == ST_OPEN) ? host_op : cur;

    assign idle_take  = (state == ST_IDLE) && !ref_req && req_valid;
    assign open_take  = (state == ST_OPEN) && (tmr == '0) && !ref_req && hit && req_valid;
    assign open_close = (state == ST_OPEN) && (tmr == '0) && ras_ok &&
                        (ref_req || (req_valid && !hit));

    assign req_ready = !ref_req &&
                       ((state == ST_IDLE) || ((state == ST_OPEN) && (tmr == '0) && hit));
    assign row_load  = idle_take;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign rd_masked[8*g +: 8] = cur.be[g] ? dq_in[8*g +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PAUSE;
            pins      <= PINS_QUIET;
            tmr       <= '0;
            init_left <= IW'(INIT_CYC);
            cur       <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            ref_ack   <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            ref_ack  <= 1'b0;
            case (state)
                ST_PAUSE: begin
                    if (pause_done) begin
                        state      <= ST_INIT_ROW;
                        pins.ras_n <= 1'b0;
                        pins.addr  <= ROW_W'(init_left);
                        tmr        <= TW'(T_RAS - 1);
                    end
                end
                ST_INIT_ROW, ST_CBR_ROW: begin
                    if (tmr == '0) begin
                        pins.ras_n <= 1'b1;
                        pins.cas_n <= '1;
                        tmr        <= TW'(T_RP - 1);
                        state      <= ST_PRECH;
                        if (state == ST_INIT_ROW) init_left <= init_left - 1'b1;
                        else                      ref_ack   <= 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (init_left != '0) begin
                        state      <= ST_INIT_ROW;
                        pins.ras_n <= 1'b0;
                        pins.addr  <= ROW_W'(init_left);
                        tmr        <= TW'(T_RAS - 1);
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (ref_req) begin
                        state      <= ST_CBR_SETUP;
                        pins.cas_n <= '0;
                    end else if (req_valid) begin
                        cur        <= host_op;
                        state      <= ST_ROW;
                        pins.ras_n <= 1'b0;
                        pins.addr  <= host_op.row;
                        tmr        <= TW'(T_RCD - 1);
                    end
                end
                ST_CBR_SETUP: begin
                    state      <= ST_CBR_ROW;
                    pins.ras_n <= 1'b0;
                    tmr        <= TW'(T_RAS - 1);
                end
                ST_ROW, ST_OPEN: begin
                    if (state == ST_OPEN && tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (state == ST_ROW && tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (open_close) begin
                        pins.ras_n <= 1'b1;
                        tmr        <= TW'(T_RP - 1);
                        state      <= ST_PRECH;
                    end else if (state == ST_ROW || open_take) begin
                        cur        <= nxt;
                        state      <= ST_COLSET;
                        pins.addr  <= {1'b0, nxt.col};
                        pins.we_n  <= !nxt.wr;
                        pins.oe_n  <= nxt.wr;
                        pins.dq_oe <= nxt.wr;
                        pins.dq    <= nxt.wdata;
                    end
                end
                ST_COLSET: begin
                    state      <= ST_STROBE;
                    pins.cas_n <= ~cur.be;
                    tmr        <= TW'(T_CAS - 1);
                end
                ST_STROBE: begin
                    if (tmr == '0) begin
                        pins.cas_n <= '1;
                        pins.we_n  <= 1'b1;
                        pins.oe_n  <= 1'b1;
                        pins.dq_oe <= 1'b0;
                        tmr        <= TW'(T_CP - 1);
                        state      <= ST_OPEN;
                        if (!cur.wr) begin
                            rd_valid <= 1'b1;
                            rd_data  <= rd_masked;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    pins  <= PINS_QUIET;
                end
            endcase
        end
    end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl import edo_pkg::*; #(
    parameter int PAUSE_CYC = 20000,
    parameter int INIT_CYC  = 8,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [NBYTE-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    host_op_t   host_op;
    dram_pins_t pins;
    logic       pause_done;
    logic       hit;
    logic       ras_ok;
    logic       row_load;

    assign host_op = pack_op(req_addr, req_we, req_be, req_wdata);

    edo_pwrup #(.PAUSE_CYC(PAUSE_CYC)) u_pwrup (
        .clk(clk), .rst(rst), .pause_done(pause_done)
    );

    edo_pagetrk #(.T_RAS(T_RAS)) u_page (
        .clk(clk), .rst(rst), .ras_n(pins.ras_n), .row_load(row_load),
        .row_in(host_op.row), .req_row(host_op.row), .hit(hit), .ras_ok(ras_ok)
    );

    edo_seq #(
        .INIT_CYC(INIT_CYC), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_seq (
        .clk(clk), .rst(rst), .pause_done(pause_done), .hit(hit), .ras_ok(ras_ok),
        .req_valid(req_valid), .host_op(host_op), .ref_req(ref_req),
        .dq_in(dram_dq_in), .req_ready(req_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .ref_ack(ref_ack), .pins(pins), .row_load(row_load)
    );

    assign dram_addr   = pins.addr;
    assign dram_ras_n  = pins.ras_n;
    assign dram_lcas_n = pins.cas_n[0];
    assign dram_ucas_n = pins.cas_n[1];
    assign dram_we_n   = pins.we_n;
    assign dram_oe_n   = pins.oe_n;
    assign dram_dq_out = pins.dq;
    assign dram_dq_oe  = pins.dq_oe;
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int INIT_CYC = 8,
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 1,
    parameter int T_RAS    = 5,
    parameter int T_RP     = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rd_valid,
    input logic        ref_req,
    input logic        ref_ack,
    input logic        dram_ras_n,
    input logic        dram_lcas_n,
    input logic        dram_ucas_n,
    input logic        dram_we_n,
    input logic        dram_oe_n,
    input logic [15:0] dram_dq_out,
    input logic        dram_dq_oe
);
    logic        cas_on;
    logic [15:0] ras_lo, ras_hi, cas_lo, cas_hi;
    logic [7:0]  ras_falls;

    assign cas_on = !dram_lcas_n || !dram_ucas_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo <= '0; ras_hi <= '0; cas_lo <= '0; cas_hi <= '0; ras_falls <= '0;
        end else begin
            ras_lo <= dram_ras_n ? 16'd0 : ((ras_lo == 16'hFFFF) ? ras_lo : ras_lo + 1'b1);
            ras_hi <= !dram_ras_n ? 16'd0 : ((ras_hi == 16'hFFFF) ? ras_hi : ras_hi + 1'b1);
            cas_lo <= !cas_on ? 16'd0 : ((cas_lo == 16'hFFFF) ? cas_lo : cas_lo + 1'b1);
            cas_hi <= cas_on ? 16'd0 : ((cas_hi == 16'hFFFF) ? cas_hi : cas_hi + 1'b1);
            if (!dram_ras_n && ras_lo == 16'd0 && ras_falls != 8'hFF) ras_falls <= ras_falls + 1'b1;
        end
    end

    // R9: row strobe low width
    p_ras_width_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |-> ras_lo >= 16'(T_RAS));
    // R8: row precharge before any new row strobe
    p_ras_prech_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> ras_hi >= 16'(T_RP));
    // R9: column strobe low width
    p_cas_width_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_on) |-> cas_lo >= 16'(T_CAS));
    // R9: column precharge inside a row period
    p_cas_prech_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cas_on) && !dram_ras_n) |-> cas_hi >= 16'(T_CP));
    // R9: row-to-column delay
    p_rcd_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cas_on) && !dram_ras_n) |-> ras_lo >= 16'(T_RCD));
    // R5: write strobes only with drivers on and output disabled
    p_wr_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (cas_on && !dram_we_n) |-> (dram_dq_oe && dram_oe_n));
    p_wr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (cas_on && $past(cas_on) && !dram_we_n) |-> $stable(dram_dq_out));
    // R10: column-before-row refresh with no write and no drive
    p_cbr_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && cas_on) |-> (dram_we_n && !dram_dq_oe));
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ref_ack |=> !ref_ack);
    p_ref_block_r10: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> !req_ready);
    // R2: no host traffic before the dummy row cycles are done
    p_init_block_r2: assert property (@(posedge clk) disable iff (rst)
        (ras_falls < 8'(INIT_CYC)) |-> !req_ready);
    // R6: read data follows a read column strobe
    p_rd_after_cas_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(cas_on) && $past(dram_we_n) && !$past(dram_oe_n)));
endmodule

bind edo_ctrl edo_ctrl_chk #(
    .INIT_CYC(INIT_CYC), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_RAS(T_RAS), .T_RP(T_RP)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
    .ref_req(ref_req), .ref_ack(ref_ack), .dram_ras_n(dram_ras_n),
    .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
);

// File: tb/edo_ctrl_test.sv
module edo_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE  = 20000;
    localparam int NINIT  = 8;
    localparam int TCAS   = 2;
    localparam int TRAS   = 5;
    localparam int TRP    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ref_req = 1'b0;
    logic        ref_ack;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = '0;

    edo_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
        .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- DRAM behavioural model ----------------
    logic [15:0] mem [int];
    int  m_row = 0, m_col = 0;
    int  ras_falls = 0, rasonly = 0, cbr_cnt = 0;
    int  lane_falls [2] = '{0, 0};
    int  lo_run = 0, hi_run = 0, min_lo = 99999, min_hi = 99999;
    logic p_ras = 1'b1;
    logic [1:0] p_cas = 2'b11;

    function automatic logic [15:0] mem_rd(input int k);
        return mem.exists(k) ? mem[k] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            logic [1:0] cas_now;
            cas_now = {dram_ucas_n, dram_lcas_n};
            if (p_ras && !dram_ras_n) begin
                if (cas_now != 2'b11) cbr_cnt++;
                else begin
                    m_row = int'(dram_addr);
                    ras_falls++;
                    if (cyc < PAUSE + 200) rasonly++;
                end
                if (hi_run < min_hi) min_hi = hi_run;
                lo_run = 1;
            end else if (!p_ras && dram_ras_n) begin
                if (lo_run < min_lo) min_lo = lo_run;
                hi_run = 1;
            end else if (dram_ras_n) hi_run++;
            else lo_run++;
            for (int l = 0; l < 2; l++) begin
                if (p_cas[l] && !cas_now[l] && !dram_ras_n) begin
                    int k;
                    logic [15:0] w;
                    m_col = int'(dram_addr[7:0]);
                    lane_falls[l]++;
                    if (!dram_we_n) begin
                        k = m_row * 256 + m_col;
                        w = mem_rd(k);
                        w[8*l +: 8] = dram_dq_out[8*l +: 8];
                        mem[k] = w;
                    end
                end
            end
            dram_dq_in = (!dram_oe_n && dram_we_n && !dram_ras_n) ? mem_rd(m_row * 256 + m_col) : 16'h0;
            p_ras = dram_ras_n;
            p_cas = cas_now;
        end
    end

    // ---------------- bench shadow ----------------
    logic [15:0] shadow [int];
    function automatic logic [15:0] exp_rd(input logic [16:0] a, input logic [1:0] be);
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction
    function automatic void sh_wr(input logic [16:0] a, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] w;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
        if (be[0]) w[7:0] = d[7:0];
        if (be[1]) w[15:8] = d[15:8];
        shadow[int'(a)] = w;
    endfunction

    logic [15:0] got;
    int lat;

    task automatic do_req(input logic [16:0] a, input bit wr, input logic [1:0] be,
                          input logic [15:0] d, input string req);
        int g = 0;
        @(negedge clk);
        req_addr = a; req_we = wr; req_be = be; req_wdata = d; req_valid = 1'b1;
        #1;
        while (!req_ready && g < 200) begin @(negedge clk); #1; g++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) sh_wr(a, be, d);
        else begin
            lat = 1;
            while (!rd_valid && lat < 100) begin @(negedge clk); lat++; end
            got = rd_data;
            chk(got == exp_rd(a, be), req, "read data", got, exp_rd(a, be));
        end
    endtask

    task automatic do_refresh();
        int g = 0;
        int c0;
        c0 = cbr_cnt;
        @(negedge clk);
        ref_req = 1'b1;
        #1;
        chk(!req_ready, "R10", "ready while refresh pending", req_ready, 0);
        while (!ref_ack && g < 200) begin @(negedge clk); g++; end
        ref_req = 1'b0;
        chk(cbr_cnt == c0 + 1, "R10", "refresh cycle count", cbr_cnt, c0 + 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(0, "ALL", "watchdog expired", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int f0, l1, g;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet pins after reset
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n && !dram_dq_oe,
            "R1", "strobes after reset", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe}, 6'b111110);
        chk(!req_ready, "R1", "ready after reset", req_ready, 0);
        repeat (PAUSE - 20) @(negedge clk);
        chk(ras_falls == 0 && !req_ready, "R1", "row strobe during pause", ras_falls, 0);
        g = 0;
        #1;
        while (!req_ready && g < 2000) begin @(negedge clk); #1; g++; end
        chk(cyc >= PAUSE, "R1", "cycles before ready", cyc, PAUSE);
        chk(rasonly == NINIT, "R2", "dummy row cycles", rasonly, NINIT);

        // R5 R6 R3: word write and read
        do_req(17'h00012, 1, 2'b11, 16'hA5C3, "R5");
        do_req(17'h00012, 0, 2'b11, 16'h0, "R6");
        chk(lat == TCAS + 2, "R6", "open-row read latency", lat, TCAS + 2);
        chk(m_row == 0 && m_col == 8'h12, "R3", "row/col at low corner", m_row * 256 + m_col, 17'h00012);

        // R8 R3: miss to the top row
        f0 = ras_falls;
        do_req(17'h1FFFF, 1, 2'b11, 16'h1234, "R8");
        do_req(17'h1FFFF, 0, 2'b11, 16'h0, "R3");
        chk(ras_falls == f0 + 1, "R8", "row opens on miss", ras_falls, f0 + 1);
        chk(m_row == 9'h1FF && m_col == 8'hFF, "R3", "row/col at high corner", m_row * 256 + m_col, 17'h1FFFF);

        // R4: byte lanes
        do_req(17'h1FFFF, 1, 2'b01, 16'hEE77, "R4");
        do_req(17'h1FFFF, 0, 2'b11, 16'h0, "R4");
        l1 = lane_falls[0];
        do_req(17'h1FFFF, 0, 2'b10, 16'h0, "R4");
        chk(lane_falls[0] == l1, "R4", "lower strobe idle on upper read", lane_falls[0], l1);
        chk(got == 16'h1200, "R4", "disabled lane zero", got, 16'h1200);

        // R7 R11: page hits, mixed
        f0 = ras_falls;
        do_req(17'h1FF00, 1, 2'b10, 16'h9900, "R11");
        do_req(17'h1FF00, 0, 2'b11, 16'h0, "R11");
        do_req(17'h1FF01, 1, 2'b11, 16'h0F0F, "R11");
        do_req(17'h1FFFF, 0, 2'b11, 16'h0, "R7");
        chk(ras_falls == f0, "R7", "no row strobe on hits", ras_falls, f0);

        // R10: refresh with a row open, data kept
        do_refresh();
        f0 = ras_falls;
        do_req(17'h00012, 0, 2'b11, 16'h0, "R10");
        chk(ras_falls == f0 + 1, "R10", "row reopened after refresh", ras_falls, f0 + 1);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [8:0] r;
            logic [1:0] be;
            case ($urandom % 4)
                0: r = 9'h000; 1: r = 9'h001; 2: r = 9'h0AA; default: r = 9'h1FF;
            endcase
            be = 2'($urandom % 3 + 1);
            do_req({r, 8'($urandom % 8)}, bit'($urandom % 2), be, 16'($urandom), "R11");
            if (i % 64 == 63) do_refresh();
        end

        chk(min_lo >= TRAS, "R9", "min row low width", min_lo, TRAS);
        chk(min_hi >= TRP, "R8", "min row precharge", min_hi, TRP);
        done = 1;
        finish_run();
    end
endmodule